// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block pulls 32-bit codec command words out of a circular ring held in system memory and hands each one to the codec link as a decoded verb. Software fills ring slots, sets a 64-bit base address, advances a write pointer and sets a run bit. The engine keeps its own 8-bit read pointer. For each new entry it issues one word read on a simple request/response memory port. It splits the returned word into a codec address, a node ID and a payload, and offers it on a valid/ready dispatch port.

An immediate-command path runs beside the ring. Software places a single verb in an immediate register and sets a busy flag. That verb goes out ahead of any further ring entry, whether or not the ring is running.

Fetching is event driven. The engine wakes on writes to the write pointer, to the control register or to the immediate busy flag, and on a pulse from the response-ring block saying its interrupt status was cleared. It then keeps fetching until the ring is empty, the run bit is clear, or the response count supplied by the response-ring block equals its threshold. It then sleeps until the next event.

The state machine has five states:
- `ST_IDLE`: evaluates the wake-up conditions.
- `ST_IMM`: presents the immediate verb.
- `ST_REQ`: holds the memory read request.
- `ST_WAIT`: waits for read data.
- `ST_SEND`: presents a fetched ring verb.

The transitions are:
- `ST_IDLE` goes to `ST_IMM` when busy is set, and to `ST_REQ` when the ring may fetch.
- `ST_IMM` goes back to `ST_IDLE` on acceptance or rejection.
- `ST_REQ` goes to `ST_WAIT` when the request is accepted.
- `ST_WAIT` goes to `ST_SEND` when the data holds a deliverable verb, and to `ST_IDLE` when it is rejected.
- `ST_SEND` goes to `ST_IDLE` on acceptance.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset the read pointer, the write pointer and the run bit are zero and the immediate busy flag is clear. No memory request or dispatch is active. A run-bit write issued right after reset therefore starts no fetch.
- R2: Each fetch reads address base + 4 × ((read pointer + 1) mod 256). When the read data returns, the read pointer takes that new index, so it only ever advances by one and wraps from 255 to 0. The base is written through select 0 (low 32 bits) and select 1 (high 32 bits).
- R3: No fetch is issued while the read pointer equals the write pointer. The write pointer is written through select 2, data bits 7:0.
- R4: Ring fetches happen only while the run bit is set. The run bit is select 3, data bit 0.
- R5: Ring fetches pause while `rsp_count` equals `rsp_thresh`.
- R6: A pending immediate verb is dispatched before the next ring entry is fetched, including when the run bit is clear. The immediate word is written through select 4.
- R7: A verb is decoded with the codec address in bits 31:28, the node ID in bits 26:20 and the payload in bits 19:0.
- R8: A verb with bit 27 set, or addressed to a codec whose `codec_present` bit is 0, is not dispatched. A rejected ring entry still advances the read pointer, and a rejected immediate verb still clears busy.
- R9: Fetching is re-evaluated only on these events: a write-pointer write, a control write, a select-5 write with bit 0 = 1, or an `rsp_irq_clr` pulse. Once it stops, a later change of `rsp_count` alone does not resume it.
- R10: Writing 1 to select 5 bit 0 sets `imm_busy`, and writing 0 there has no effect. `imm_busy` clears when the immediate verb is accepted or rejected.
- R11: At most one memory read is outstanding. A request stays asserted with a stable address until it is accepted.
- R12: A dispatched verb stays valid with stable fields until `cmd_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low controller reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 base low, 1 base high, 2 write pointer, 3 control, 4 immediate word, 5 immediate status) |
| cfg_wdata | input | 32 | Register write data |
| codec_present | input | 16 | One bit per codec address, set when a codec is attached |
| rsp_count | input | 8 | Response count from the response-ring block |
| rsp_thresh | input | 8 | Response threshold from the response-ring block |
| rsp_irq_clr | input | 1 | Pulse: response-ring interrupt status was cleared |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 64 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| cmd_valid | output | 1 | Decoded verb valid |
| cmd_ready | input | 1 | Codec link accepts the verb |
| cmd_cad | output | 4 | Codec address of the verb |
| cmd_nid | output | 7 | Node ID of the verb |
| cmd_payload | output | 20 | Verb payload |
| rd_ptr | output | 8 | Current ring read pointer |
| imm_busy | output | 1 | Immediate verb pending |

## Verification
The hardest situation to reach is the event-driven sleep. The engine must stall on an equal response count, then stay asleep when that count moves away with no wake-up event, and resume only on the `rsp_irq_clr` pulse. The bench builds this in three steps, checking the request count after each: it holds the count equal to the threshold, advances the write pointer, and then changes the count alone.

A second hard case is an immediate verb arriving while a ring verb is stuck at dispatch. The bench holds `cmd_ready` low until the engine sits on a fetched verb, then sets the immediate busy flag. A scoreboard then checks the order ring, immediate, ring.

// File: rtl/cmd_ring_pkg.sv
`timescale 1ns/1ps
package cmd_ring_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IMM,
        ST_REQ,
        ST_WAIT,
        ST_SEND
    } fetch_state_e;

    typedef enum logic [2:0] {
        SEL_BASE_LO  = 3'd0,
        SEL_BASE_HI  = 3'd1,
        SEL_WR_PTR   = 3'd2,
        SEL_CTRL     = 3'd3,
        SEL_IMM_CMD  = 3'd4,
        SEL_IMM_STAT = 3'd5
    } cfg_sel_e;

    // Verb layout: the field positions are fixed by the codec link.
    typedef struct packed {
        logic [3:0]  cad;
        logic        indirect;
        logic [6:0]  nid;
        logic [19:0] payload;
    } verb_t;

    localparam int VERB_W = $bits(verb_t);
    localparam int CAD_W  = 4;

endpackage

// File: rtl/cmd_ring_regs.sv
`timescale 1ns/1ps
module cmd_ring_regs
    import cmd_ring_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              rsp_irq_clr,
    input  logic              kick_clr,
    input  logic              imm_done,
    output logic [63:0]       base_full,
    output logic [IDX_W-1:0]  wr_ptr,
    output logic              run,
    output logic [VERB_W-1:0] imm_word,
    output logic              imm_busy,
    output logic              kick
);

    logic [31:0] base_lo;
    logic [31:0] base_hi;
    logic        busy_set;
    logic        wake;

    assign busy_set  = cfg_we && (cfg_sel == SEL_IMM_STAT) && cfg_wdata[0];
    assign wake      = rsp_irq_clr || busy_set ||
                       (cfg_we && ((cfg_sel == SEL_WR_PTR) || (cfg_sel == SEL_CTRL)));
    assign base_full = {base_hi, base_lo};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_lo  <= '0;
            base_hi  <= '0;
            wr_ptr   <= '0;
            run      <= 1'b0;
            imm_word <= '0;
            imm_busy <= 1'b0;
            kick     <= 1'b0;
        end else begin
            if (cfg_we) begin
                case (cfg_sel)
                    SEL_BASE_LO: base_lo  <= cfg_wdata;
                    SEL_BASE_HI: base_hi  <= cfg_wdata;
                    SEL_WR_PTR:  wr_ptr   <= cfg_wdata[IDX_W-1:0];
                    SEL_CTRL:    run      <= cfg_wdata[0];
                    SEL_IMM_CMD: imm_word <= cfg_wdata;
                    default: ;
                endcase
            end
            if (busy_set) begin
                imm_busy <= 1'b1;
            end else if (imm_done) begin
                imm_busy <= 1'b0;
            end
            if (wake) begin
                kick <= 1'b1;
            end else if (kick_clr) begin
                kick <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cmd_verb_decode.sv
`timescale 1ns/1ps
module cmd_verb_decode
    import cmd_ring_pkg::*;
#(
    parameter int NUM_CODECS = 16
) (
    input  logic [VERB_W-1:0]     word,
    input  logic [NUM_CODECS-1:0] codec_present,
    output logic [CAD_W-1:0]      cad,
    output logic [6:0]            nid,
    output logic [19:0]           payload,
    output logic                  accept
);

    verb_t v;

    assign v       = verb_t'(word);
    assign cad     = v.cad;
    assign nid     = v.nid;
    assign payload = v.payload;
    // Indirect node addressing is refused; so is an address with no codec behind it.
    assign accept  = !v.indirect && codec_present[v.cad];

endmodule

// File: rtl/cmd_ring_fsm.sv
`timescale 1ns/1ps
module cmd_ring_fsm
    import cmd_ring_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  wr_ptr,
    input  logic              run,
    input  logic              kick,
    input  logic              imm_busy,
    input  logic [VERB_W-1:0] imm_word,
    input  logic [CNT_W-1:0]  rsp_count,
    input  logic [CNT_W-1:0]  rsp_thresh,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [VERB_W-1:0] mem_rsp_data,
    output logic [VERB_W-1:0] dec_word,
    input  logic              dec_accept,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              kick_clr,
    output logic              imm_done,
    output logic [IDX_W-1:0]  rd_ptr
);

    localparam int PAD_W = ADDR_W - IDX_W - 2;

    fetch_state_e      state_q, state_d;
    logic [VERB_W-1:0] held_q;
    logic [IDX_W-1:0]  nxt_idx;
    logic              ring_go;

    assign nxt_idx      = rd_ptr + 1'b1;
    assign mem_req_addr = base + {{PAD_W{1'b0}}, nxt_idx, 2'b00};
    assign ring_go      = kick && run && (rd_ptr != wr_ptr) && (rsp_count != rsp_thresh);

    // State register and the data captured on a read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_ptr  <= '0;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT && mem_rsp_valid) begin
                rd_ptr <= nxt_idx;
                held_q <= mem_rsp_data;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (imm_busy)     state_d = ST_IMM;
                else if (ring_go) state_d = ST_REQ;
            end
            ST_IMM:  if (!dec_accept || cmd_ready) state_d = ST_IDLE;
            ST_REQ:  if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) state_d = dec_accept ? ST_SEND : ST_IDLE;
            ST_SEND: if (cmd_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req_valid = (state_q == ST_REQ);
        cmd_valid     = (state_q == ST_SEND) || ((state_q == ST_IMM) && dec_accept);
        imm_done      = (state_q == ST_IMM) && (!dec_accept || cmd_ready);
        kick_clr      = (state_q == ST_IDLE) && !imm_busy && !ring_go;
        unique case (state_q)
            ST_IMM:  dec_word = imm_word;
            ST_WAIT: dec_word = mem_rsp_data;
            default: dec_word = held_q;
        endcase
    end

endmodule

// File: rtl/cmd_ring_fetch.sv
`timescale 1ns/1ps
module cmd_ring_fetch
    import cmd_ring_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_sel,
    input  logic [31:0]           cfg_wdata,
    input  logic [(1<<CAD_W)-1:0] codec_present,
    input  logic [CNT_W-1:0]      rsp_count,
    input  logic [CNT_W-1:0]      rsp_thresh,
    input  logic                  rsp_irq_clr,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [ADDR_W-1:0]     mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [31:0]           mem_rsp_data,
    output logic                  cmd_valid,
    input  logic                  cmd_ready,
    output logic [CAD_W-1:0]      cmd_cad,
    output logic [6:0]            cmd_nid,
    output logic [19:0]           cmd_payload,
    output logic [IDX_W-1:0]      rd_ptr,
    output logic                  imm_busy
);

    localparam int NUM_CODECS = 1 << CAD_W;

    logic [63:0]       base_full;
    logic [IDX_W-1:0]  wr_ptr;
    logic              run;
    logic [VERB_W-1:0] imm_word;
    logic              kick;
    logic              kick_clr;
    logic              imm_done;
    logic [VERB_W-1:0] dec_word;
    logic              dec_accept;

    cmd_ring_regs #(.IDX_W(IDX_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .rsp_irq_clr (rsp_irq_clr),
        .kick_clr    (kick_clr),
        .imm_done    (imm_done),
        .base_full   (base_full),
        .wr_ptr      (wr_ptr),
        .run         (run),
        .imm_word    (imm_word),
        .imm_busy    (imm_busy),
        .kick        (kick)
    );

    cmd_ring_fsm #(.IDX_W(IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .base          (base_full[ADDR_W-1:0]),
        .wr_ptr        (wr_ptr),
        .run           (run),
        .kick          (kick),
        .imm_busy      (imm_busy),
        .imm_word      (imm_word),
        .rsp_count     (rsp_count),
        .rsp_thresh    (rsp_thresh),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .dec_word      (dec_word),
        .dec_accept    (dec_accept),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .kick_clr      (kick_clr),
        .imm_done      (imm_done),
        .rd_ptr        (rd_ptr)
    );

    cmd_verb_decode #(.NUM_CODECS(NUM_CODECS)) u_dec (
        .word          (dec_word),
        .codec_present (codec_present),
        .cad           (cmd_cad),
        .nid           (cmd_nid),
        .payload       (cmd_payload),
        .accept        (dec_accept)
    );

endmodule

// File: rtl/cmd_ring_checker.sv
`timescale 1ns/1ps
module cmd_ring_checker #(
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [3:0]        cmd_cad,
    input logic [6:0]        cmd_nid,
    input logic [19:0]       cmd_payload,
    input logic [15:0]       codec_present,
    input logic [IDX_W-1:0]  rd_ptr,
    input logic [IDX_W-1:0]  wr_ptr,
    input logic              run,
    input logic [CNT_W-1:0]  rsp_count,
    input logic [CNT_W-1:0]  rsp_thresh
);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable({cmd_cad, cmd_nid, cmd_payload}));

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_ptr) |-> rd_ptr == ($past(rd_ptr) + 1'b1));

    assert_ptr_on_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_ptr) |-> $past(mem_rsp_valid));

    assert_target_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> codec_present[cmd_cad]);

    assert_req_not_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(rd_ptr != wr_ptr));

    assert_req_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(run));

    assert_req_below_thresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(rsp_count != rsp_thresh));

endmodule

bind cmd_ring_fetch cmd_ring_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_cmd_ring_fetch.sv
`timescale 1ns/1ps
module test_cmd_ring_fetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] codec_present = 16'h0025;
    logic [7:0]  rsp_count = 8'd0;
    logic [7:0]  rsp_thresh = 8'hff;
    logic        rsp_irq_clr = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [3:0]  cmd_cad;
    logic [6:0]  cmd_nid;
    logic [19:0] cmd_payload;
    logic [7:0]  rd_ptr;
    logic        imm_busy;

    always #2.5 clk = ~clk;

    cmd_ring_fetch i_cmd_ring_fetch (.*);

    localparam logic [63:0] BASE = 64'h0000_0012_3456_7800;

    int          checks = 0;
    int          errors = 0;
    int          n_req = 0;
    int          cyc = 0;
    logic        cmd_hold = 1'b0;
    logic [31:0] ring [256];
    logic [63:0] exp_addr [$];
    logic [30:0] exp_cmd [$];

    function automatic logic [30:0] fields(input logic [31:0] w);
        return {w[31:28], w[26:20], w[19:0]};
    endfunction

    function automatic logic deliverable(input logic [31:0] w);
        return !w[27] && codec_present[w[31:28]];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic expect_ring(input int idx);
        exp_addr.push_back(BASE + 64'(4 * idx));
        if (deliverable(ring[idx])) exp_cmd.push_back(fields(ring[idx]));
    endtask

    task automatic drain(input string req);
        int t = 0;
        while ((exp_cmd.size() != 0 || exp_addr.size() != 0) && t < 5000) begin
            tick(1);
            t++;
        end
        tick(10);
        check({req, " scoreboard empty"}, 64'(exp_cmd.size() + exp_addr.size()), 64'd0);
    endtask

    // Ready patterns, driven just after each rising edge
    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            mem_req_ready = (cyc % 3) != 0;
            cmd_ready     = !cmd_hold && ((cyc % 4) != 1);
        end
    end

    // Memory model and address monitor (R2)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid && mem_req_ready) begin
                logic [63:0] a;
                a = mem_req_addr;
                n_req++;
                if (exp_addr.size() == 0) begin
                    check("R3 unexpected fetch", a, 64'hffff_ffff_ffff_ffff);
                end else begin
                    check("R2 fetch address", a, exp_addr.pop_front());
                end
                @(posedge clk); #1;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = ring[8'((a - BASE) >> 2)];
                @(posedge clk); #1;
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // Dispatch monitor (R7, R8)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid && cmd_ready) begin
                if (exp_cmd.size() == 0) begin
                    check("R8 unexpected dispatch", 64'({cmd_cad, cmd_nid, cmd_payload}), 64'h7fff_ffff_ffff_ffff);
                end else begin
                    check("R7 verb fields", 64'({cmd_cad, cmd_nid, cmd_payload}), 64'(exp_cmd.pop_front()));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base_req;
        logic [31:0] imm_v;
        for (int i = 0; i < 256; i++) begin
            logic [3:0] c;
            c = (i % 3 == 0) ? 4'd0 : ((i % 3 == 1) ? 4'd2 : 4'd5);
            ring[i] = {c, 1'b0, 7'(i * 3), 20'(i * 4099)};
        end
        ring[4] = {4'd0, 1'b1, 7'h11, 20'h12345};
        ring[5] = {4'd1, 1'b0, 7'h22, 20'h54321};

        tick(3);
        check("R1 rd_ptr at reset", 64'(rd_ptr), 64'd0);
        check("R1 imm_busy at reset", 64'(imm_busy), 64'd0);
        check("R1 no request at reset", 64'(mem_req_valid), 64'd0);
        check("R1 no dispatch at reset", 64'(cmd_valid), 64'd0);
        rst_n = 1'b1;
        tick(2);

        // R4: entries pending but run clear
        wr(3'd0, BASE[31:0]);
        wr(3'd1, BASE[63:32]);
        wr(3'd2, 32'd3);
        tick(20);
        check("R4 no fetch while stopped", 64'(n_req), 64'd0);
        for (int i = 1; i <= 3; i++) expect_ring(i);
        wr(3'd3, 32'd1);
        drain("R4");
        check("R2 rd_ptr after run", 64'(rd_ptr), 64'd3);

        // R3: write pointer equal to read pointer
        base_req = n_req;
        wr(3'd2, 32'd3);
        tick(20);
        check("R3 empty ring fetches nothing", 64'(n_req - base_req), 64'd0);

        // R8: indirect and absent-codec entries are consumed but not sent
        for (int i = 4; i <= 6; i++) expect_ring(i);
        wr(3'd2, 32'd6);
        drain("R8");
        check("R8 rd_ptr past rejected entries", 64'(rd_ptr), 64'd6);

        // R5 / R9: threshold stall and event-driven resume
        rsp_thresh = 8'd2;
        rsp_count  = 8'd2;
        base_req = n_req;
        wr(3'd2, 32'd8);
        tick(20);
        check("R5 stalled at threshold", 64'(n_req - base_req), 64'd0);
        rsp_count = 8'd0;
        tick(20);
        check("R9 no resume without event", 64'(n_req - base_req), 64'd0);
        expect_ring(7);
        expect_ring(8);
        @(posedge clk); #1; rsp_irq_clr = 1'b1;
        @(posedge clk); #1; rsp_irq_clr = 1'b0;
        drain("R9");
        check("R9 rd_ptr after resume", 64'(rd_ptr), 64'd8);

        // R6 / R10: immediate verb overtakes the rest of the ring
        imm_v = {4'd2, 1'b0, 7'h5a, 20'habcde};
        exp_addr.push_back(BASE + 64'(4 * 9));
        exp_addr.push_back(BASE + 64'(4 * 10));
        exp_addr.push_back(BASE + 64'(4 * 11));
        exp_cmd.push_back(fields(ring[9]));
        exp_cmd.push_back(fields(imm_v));
        exp_cmd.push_back(fields(ring[10]));
        exp_cmd.push_back(fields(ring[11]));
        cmd_hold = 1'b1;
        wr(3'd2, 32'd11);
        tick(15);
        check("R6 stuck on first ring verb", 64'(cmd_valid), 64'd1);
        wr(3'd4, imm_v);
        wr(3'd5, 32'd1);
        check("R10 busy set by status write", 64'(imm_busy), 64'd1);
        cmd_hold = 1'b0;
        drain("R6");
        check("R10 busy cleared after dispatch", 64'(imm_busy), 64'd0);
        check("R6 rd_ptr after mixed order", 64'(rd_ptr), 64'd11);

        // R6 / R10 / R8: immediate with run clear, ignored zero write, rejected immediate
        wr(3'd3, 32'd0);
        imm_v = {4'd5, 1'b0, 7'h03, 20'h00777};
        exp_cmd.push_back(fields(imm_v));
        cmd_hold = 1'b1;
        wr(3'd4, imm_v);
        wr(3'd5, 32'd1);
        wr(3'd5, 32'd0);
        tick(3);
        check("R10 zero write leaves busy", 64'(imm_busy), 64'd1);
        cmd_hold = 1'b0;
        drain("R6 immediate while stopped");
        wr(3'd4, {4'd0, 1'b1, 7'h01, 20'h00001});
        wr(3'd5, 32'd1);
        tick(10);
        check("R8 rejected immediate clears busy", 64'(imm_busy), 64'd0);
        check("R8 rejected immediate not sent", 64'(exp_cmd.size()), 64'd0);

        // R2: long run across the 255 -> 0 wrap
        for (int i = 12; i < 256; i++) expect_ring(i);
        expect_ring(0);
        expect_ring(1);
        wr(3'd2, 32'd1);
        wr(3'd3, 32'd1);
        drain("R2 wrap");
        check("R2 rd_ptr after wrap", 64'(rd_ptr), 64'd1);

        // R1: controller reset in the middle of use
        @(posedge clk); #1; rst_n = 1'b0;
        tick(3);
        check("R1 rd_ptr after reset", 64'(rd_ptr), 64'd0);
        check("R1 busy after reset", 64'(imm_busy), 64'd0);
        rst_n = 1'b1;
        rsp_count = 8'd0; rsp_thresh = 8'hff;
        base_req = n_req;
        wr(3'd3, 32'd1);
        tick(20);
        check("R1 write pointer reset, nothing to fetch", 64'(n_req - base_req), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule